// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block keeps the 8-bit status word of a serial flash device. It also rules on every write-type request that the command engine decodes. The write-enable latch, the two-bit protection level, the protect-enable bit and the in-progress flag are held here. A hardware write-protect pin is sampled so that status writes can be locked from outside the device.

The command engine raises one-cycle request pulses:

- set latch
- clear latch
- status write, with its data byte
- program, with an address
- sector erase, with an address
- chip erase

The unit answers a write-type request in the same cycle with either `grant_o` or `deny_o`. After a grant, the in-progress flag stays set until the engine reports `op_done_i`. While that flag is set, `status_o` reads as all ones. The array contents and the serial shifting are handled elsewhere.

Top module: `flash_wp_status`

## Requirements
- R1: While reset is active, and after reset is released, `status_o` equals {PE_RST, 000, LVL_RST, 0, 0} until a request changes it. With the default parameters this value is 8'h0C.
- R2: When the in-progress flag is clear, `status_o` has this layout:
  - bit 7: protect-enable.
  - bits 6..4: zero.
  - bits 3..2: protection level.
  - bit 1: write-enable latch.
  - bit 0: zero, meaning ready.
- R3: While a granted operation is in progress, `status_o` reads 8'hFF.
- R4: While idle, a set pulse writes 1 to the latch and a clear pulse writes 0. These pulses have no effect while an operation is in progress, or in a cycle that also carries a write-type request.
- R5: The sector is taken from address bits 17..16. Address bits 23..18 are ignored. The protection level decides which sectors are locked:
  - Level 00 locks no sector.
  - Level 01 locks sector 3 (addresses 030000–03FFFF).
  - Level 10 locks sectors 2 and 3 (addresses 020000–03FFFF).
  - Level 11 locks all four sectors.
  A program or sector erase whose target is in a locked sector is denied.
- R6: A program or sector erase to an unlocked sector is granted only when the latch is 1.
- R7: A chip erase is denied whenever the protection level is not 00. Otherwise it is granted when the latch is 1.
- R8: A status write is denied when the latch is 0, or when protect-enable is 1 and `wp_i` is low. Otherwise it is granted.
- R9: A granted status write copies only data bits 7, 3 and 2 into the status word.
- R10: Any grant sets the in-progress flag. The next `op_done_i` clears both the in-progress flag and the latch.
- R11: A write-type request that is denied while idle clears the latch.
- R12: Every write-type request gets exactly one of `grant_o` or `deny_o`, combinationally, in the cycle it is presented. A write-type request made while an operation is in progress is denied and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_wel_i | input | 1 | Set write-enable latch request |
| clr_wel_i | input | 1 | Clear write-enable latch request |
| wrsr_i | input | 1 | Status write request |
| wrsr_data_i | input | 8 | Status write data |
| prog_i | input | 1 | Program request |
| serase_i | input | 1 | Sector erase request |
| cerase_i | input | 1 | Chip erase request |
| addr_i | input | 24 | Target address for program and sector erase |
| wp_i | input | 1 | Write-protect pin, low means protect |
| op_done_i | input | 1 | Self-timed operation finished |
| status_o | output | 8 | Status word |
| grant_o | output | 1 | Request accepted |
| deny_o | output | 1 | Request refused |

## Verification
The embedded properties are checked on every cycle. They cover:
- that `grant_o` and `deny_o` are mutually exclusive and complete;
- that a grant is followed by an all-ones status;
- that completion and refusal both drop the latch;
- that the pin lock on status writes holds;
- that a chip erase is never granted under a nonzero level.

Some behaviour needs sequences that only the bench scenarios build. These cover:
- the exact sector boundaries of each level;
- that upper address bits are ignored;
- that status writes alter only the three writable bits;
- that latch pulses are ignored mid-operation;
- the full sequence of a level change followed by a chip erase.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WRSR   = 3'd1,
    OP_PROG   = 3'd2,
    OP_SERASE = 3'd3,
    OP_CERASE = 3'd4
  } fwp_op_e;
endpackage

// File: rtl/fwp_lock.sv
module fwp_lock #(
  parameter int ADDR_W  = 24,
  parameter int ARRAY_W = 18,
  parameter int SEC_W   = 2
) (
  input  logic [1:0]        level_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sec_locked_o,
  output logic              any_locked_o
);
  localparam int NSEC = 1 << SEC_W;

  logic [SEC_W-1:0] sec;
  int               nlock;
  logic [NSEC-1:0]  lock_vec;
  logic             unused_addr_bits;

  assign sec = addr_i[ARRAY_W-1 -: SEC_W];
  assign unused_addr_bits = ^{addr_i[ADDR_W-1:ARRAY_W], addr_i[ARRAY_W-SEC_W-1:0]};

  // number of top sectors locked by the level code
  always_comb begin
    unique case (level_i)
      2'b00:   nlock = 0;
      2'b01:   nlock = NSEC / 4;
      2'b10:   nlock = NSEC / 2;
      default: nlock = NSEC;
    endcase
  end

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    assign lock_vec[g] = (nlock + g >= NSEC);
  end

  assign sec_locked_o = lock_vec[sec];
  assign any_locked_o = |lock_vec;
endmodule

// File: rtl/fwp_policy.sv
module fwp_policy
  import fwp_pkg::*;
(
  input  fwp_op_e op_i,
  input  logic    wel_i,
  input  logic    busy_i,
  input  logic    pe_i,
  input  logic    wp_i,
  input  logic    sec_locked_i,
  input  logic    any_locked_i,
  output logic    grant_o,
  output logic    deny_o
);
  logic allow;

  always_comb begin
    unique case (op_i)
      OP_WRSR:           allow = wel_i && !(pe_i && !wp_i);
      OP_PROG, OP_SERASE: allow = wel_i && !sec_locked_i;
      OP_CERASE:         allow = wel_i && !any_locked_i;
      default:           allow = 1'b0;
    endcase
    grant_o = (op_i != OP_NONE) && !busy_i && allow;
    deny_o  = (op_i != OP_NONE) && !grant_o;
  end
endmodule

// File: rtl/fwp_state.sv
module fwp_state #(
  parameter logic [1:0] LVL_RST = 2'b11,
  parameter logic       PE_RST  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       grant_i,
  input  logic       deny_i,
  input  logic       is_wrsr_i,
  input  logic [7:0] data_i,
  input  logic       done_i,
  output logic       wel_o,
  output logic       busy_o,
  output logic [1:0] level_o,
  output logic       pe_o
);
  logic       wel_q, wel_d, busy_q, busy_d, pe_q, pe_d, upd;
  logic [1:0] lvl_q, lvl_d;
  logic       unused_data_bits;

  assign unused_data_bits = ^{data_i[6:4], data_i[1:0]};

  always_comb begin
    wel_d  = wel_q;
    busy_d = busy_q;
    pe_d   = pe_q;
    lvl_d  = lvl_q;
    if (busy_q) begin
      if (done_i) begin
        busy_d = 1'b0;
        wel_d  = 1'b0;
      end
    end else if (grant_i) begin
      busy_d = 1'b1;
      if (is_wrsr_i) begin
        pe_d  = data_i[7];
        lvl_d = data_i[3:2];
      end
    end else if (deny_i || clr_wel_i) begin
      wel_d = 1'b0;
    end else if (set_wel_i) begin
      wel_d = 1'b1;
    end
  end

  assign upd = busy_q ? done_i : (grant_i | deny_i | clr_wel_i | set_wel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
      pe_q   <= PE_RST;
      lvl_q  <= LVL_RST;
    end else if (upd) begin
      wel_q  <= wel_d;
      busy_q <= busy_d;
      pe_q   <= pe_d;
      lvl_q  <= lvl_d;
    end
  end

  assign wel_o   = wel_q;
  assign busy_o  = busy_q;
  assign level_o = lvl_q;
  assign pe_o    = pe_q;

  p_done_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && done_i) |=> (!busy_q && !wel_q));
  p_deny_drops_wel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && deny_i) |=> !wel_q);
  p_busy_holds_state_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_i) |=> ($stable(lvl_q) && $stable(pe_q) && busy_q));
endmodule

// File: rtl/flash_wp_status.sv
module flash_wp_status
  import fwp_pkg::*;
#(
  parameter int         ADDR_W  = 24,
  parameter int         ARRAY_W = 18,
  parameter int         SEC_W   = 2,
  parameter logic [1:0] LVL_RST = 2'b11,
  parameter logic       PE_RST  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              prog_i,
  input  logic              serase_i,
  input  logic              cerase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  input  logic              op_done_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              deny_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  fwp_op_e    op;
  logic       wel, busy, pe, sec_locked, any_locked;
  logic [1:0] level;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // highest-priority request wins if several arrive together
  always_comb begin
    if      (wrsr_i)   op = OP_WRSR;
    else if (prog_i)   op = OP_PROG;
    else if (serase_i) op = OP_SERASE;
    else if (cerase_i) op = OP_CERASE;
    else               op = OP_NONE;
  end

  fwp_lock #(.ADDR_W(ADDR_W), .ARRAY_W(ARRAY_W), .SEC_W(SEC_W)) u_lock (
    .level_i      (level),
    .addr_i       (addr_i),
    .sec_locked_o (sec_locked),
    .any_locked_o (any_locked)
  );

  fwp_policy u_policy (
    .op_i         (op),
    .wel_i        (wel),
    .busy_i       (busy),
    .pe_i         (pe),
    .wp_i         (wp_i),
    .sec_locked_i (sec_locked),
    .any_locked_i (any_locked),
    .grant_o      (grant_o),
    .deny_o       (deny_o)
  );

  fwp_state #(.LVL_RST(LVL_RST), .PE_RST(PE_RST)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .set_wel_i (set_wel_i),
    .clr_wel_i (clr_wel_i),
    .grant_i   (grant_o),
    .deny_i    (deny_o),
    .is_wrsr_i (op == OP_WRSR),
    .data_i    (wrsr_data_i),
    .done_i    (op_done_i),
    .wel_o     (wel),
    .busy_o    (busy),
    .level_o   (level),
    .pe_o      (pe)
  );

  assign status_o = busy ? 8'hFF : {pe, 3'b000, level, wel, 1'b0};

  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(grant_o && deny_o));
  p_answer_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wrsr_i || prog_i || serase_i || cerase_i) |-> (grant_o || deny_o));
  p_grant_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    grant_o |=> (status_o == 8'hFF));
  p_pin_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wrsr_i && status_o[7] && !status_o[0] && !wp_i) |-> !grant_o);
  p_chip_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op == OP_CERASE && status_o[3:2] != 2'b00 && !status_o[0]) |-> !grant_o);
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy |-> (status_o[6:4] == 3'b000 && !status_o[0]));
endmodule

// File: tb/sim_flash_wp_status.sv
module sim_flash_wp_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw, cw, wr, pg, se, ce, wp, dn;
  logic [7:0]  d;
  logic [23:0] a;
  logic [7:0]  status;
  logic        grant, deny;
  int          n_cmp = 0, n_bad = 0;
  int          m_wel, m_busy, m_pe, m_lvl;

  always #2.5 clk = ~clk;

  flash_wp_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .set_wel_i(sw), .clr_wel_i(cw), .wrsr_i(wr),
    .wrsr_data_i(d), .prog_i(pg), .serase_i(se), .cerase_i(ce), .addr_i(a),
    .wp_i(wp), .op_done_i(dn), .status_o(status), .grant_o(grant), .deny_o(deny)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit s_w, c_w, w_r, p_g, s_e, c_e, input logic [23:0] ad,
                      input logic [7:0] dat, input bit pin, input bit done, input string tag);
    int op, sec, nl, locked, allow, eg, ed, est;
    @(negedge clk);
    sw = s_w; cw = c_w; wr = w_r; pg = p_g; se = s_e; ce = c_e;
    a = ad; d = dat; wp = pin; dn = done;
    #1;
    op = w_r ? 1 : p_g ? 2 : s_e ? 3 : c_e ? 4 : 0;
    sec = (ad >> 16) & 3;
    nl = (m_lvl == 0) ? 0 : (m_lvl == 1) ? 1 : (m_lvl == 2) ? 2 : 4;
    locked = (sec >= 4 - nl);
    case (op)
      1: allow = m_wel && !(m_pe && !pin);
      2, 3: allow = m_wel && !locked;
      4: allow = m_wel && (m_lvl == 0);
      default: allow = 0;
    endcase
    eg = (op != 0) && !m_busy && allow;
    ed = (op != 0) && !eg;
    est = m_busy ? 8'hFF : (m_pe * 128 + m_lvl * 4 + m_wel * 2);
    cmp(tag, "status", int'(status), est);
    cmp(tag, "grant", int'(grant), eg);
    cmp(tag, "deny", int'(deny), ed);
    if (m_busy) begin
      if (done) begin m_busy = 0; m_wel = 0; end
    end else if (op != 0) begin
      if (eg) begin
        m_busy = 1;
        if (op == 1) begin m_pe = dat[7]; m_lvl = dat[3:2]; end
      end else m_wel = 0;
    end else if (c_w) m_wel = 0;
    else if (s_w) m_wel = 1;
  endtask

  task automatic idle(input string tag);
    step(0,0,0,0,0,0, 24'h0, 8'h0, 1, 0, tag);
  endtask
  task automatic setw(input string tag);
    step(1,0,0,0,0,0, 24'h0, 8'h0, 1, 0, tag);
  endtask
  task automatic done(input string tag);
    step(0,0,0,0,0,0, 24'h0, 8'h0, 1, 1, tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_wel = 0; m_busy = 0; m_pe = 0; m_lvl = 3;
    sw = 0; cw = 0; wr = 0; pg = 0; se = 0; ce = 0; wp = 1; dn = 0; a = '0; d = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 cmp("R1", "status in reset", int'(status), 8'h0C);
    rst_n = 1'b1;
    repeat (3) idle("R1");
    // latch and protection basics
    step(0,0,0,1,0,0, 24'h000000, 8'h0, 1, 0, "R6");   // no latch
    setw("R4");
    step(0,0,0,1,0,0, 24'h000000, 8'h0, 1, 0, "R5");   // all locked
    idle("R11");
    // open the array with a status write, pin low but protect-enable off
    setw("R4");
    step(0,0,1,0,0,0, 24'h0, 8'h00, 0, 0, "R8");
    idle("R3");
    setw("R4");                                         // ignored while busy
    step(0,0,0,1,0,0, 24'h000000, 8'h0, 1, 0, "R12");  // denied while busy
    done("R10");
    idle("R2");
    setw("R4");
    step(0,1,0,0,0,0, 24'h0, 8'h0, 1, 0, "R4");
    idle("R4");
    setw("R4");
    step(1,0,0,1,0,0, 24'h010000, 8'h0, 1, 0, "R4");    // latch pulse with request
    done("R10");
    // level 01 with protect-enable; junk in unused bits
    setw("R9");
    step(0,0,1,0,0,0, 24'h0, 8'hF5, 1, 0, "R9");
    done("R9");
    idle("R9");
    setw("R5");
    step(0,0,0,1,0,0, 24'h030000, 8'h0, 1, 0, "R5");
    setw("R5");
    step(0,0,0,1,0,0, 24'h02FFFF, 8'h0, 1, 0, "R5");
    done("R10");
    setw("R5");
    step(0,0,0,0,1,0, 24'hFF0000, 8'h0, 1, 0, "R5");   // upper bits ignored
    setw("R7");
    step(0,0,0,0,0,1, 24'h0, 8'h0, 1, 0, "R7");
    // pin lock on status writes
    setw("R8");
    step(0,0,1,0,0,0, 24'h0, 8'h00, 0, 0, "R8");
    setw("R8");
    step(0,0,1,0,0,0, 24'h0, 8'h88, 1, 0, "R8");
    done("R10");
    idle("R2");
    // level 10
    setw("R5");
    step(0,0,0,0,1,0, 24'h020000, 8'h0, 1, 0, "R5");
    setw("R5");
    step(0,0,0,0,1,0, 24'h01ABCD, 8'h0, 1, 0, "R5");
    done("R10");
    step(0,0,0,1,0,0, 24'h000000, 8'h0, 1, 0, "R6");
    // clear protection, then chip erase
    setw("R8");
    step(0,0,1,0,0,0, 24'h0, 8'h00, 1, 0, "R8");
    done("R10");
    setw("R7");
    step(0,0,0,0,0,1, 24'h0, 8'h0, 1, 0, "R7");
    idle("R3");
    done("R10");
    idle("R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule